// File: doc/BRIEF.md
# Two-Candidate Block Adder

This block is a purely combinational binary adder that returns `a + b + cin` as a sum and a carry-out. The operands are divided into contiguous bit blocks. The lowest block is one ripple-carry chain that takes the external carry directly. Every block above it computes two candidate results at the same time, one that assumes an incoming carry of zero and one that assumes an incoming carry of one. The carry that actually arrives from below then chooses between the two candidate sums with a 2:1 multiplexer.

The carry-out of each upper block is built from two signals. The generate signal is the carry-out of the zero-assumption chain. The propagate signal is the carry-out of the one-assumption chain. The block carry is then generate OR (propagate AND incoming carry). This carry is the select for the next block up, and the carry of the top block is the adder's carry-out. The candidate chains never wait for each other, so the carry path only passes through one AND-OR stage per block.

The layout is fixed at elaboration. In the uniform layout every block is `BLK_W` bits wide. In the progressive layout the two lowest blocks are both `BLK_W` wide and each block above is one bit wider than the block beneath it. In both layouts, if the blocks do not divide `WIDTH` evenly, the top block is cut down to the bits that remain.

Top module: `csa_adder`

## Requirements
- R1: In the uniform layout (`LAYOUT = LAYOUT_UNIFORM`), `{cout, sum}` equals the exact `WIDTH+1`-bit value of `a + b + cin` for every input combination.
- R2: In the progressive layout (`LAYOUT = LAYOUT_PROGRESSIVE`), block widths run `BLK_W`, `BLK_W`, `BLK_W+1`, `BLK_W+2`, and so on. `{cout, sum}` still equals `a + b + cin` exactly for every input.
- R3: An upper block outputs its carry-one candidate sum when the carry entering it is 1, and its carry-zero candidate when that carry is 0. Example: `a=16'h000F`, `b=0`, `cin=1` gives `sum=16'h0010` with the default 4-bit blocks.
- R4: For every upper block, the generate signal implies the propagate signal. The block carry-out is 1 exactly when generate is 1, or when propagate is 1 and the incoming carry is 1.
- R5: All-ones operands with `cin=1` give a sum of all ones and `cout=1`.
- R6: When `WIDTH` is not a multiple of the block widths, the top block covers only the remaining bits. Example: a 7-bit adder with 3-bit blocks uses blocks of 3, 3 and 1 bits, and it is still exact.
- R7: The lowest block is fed directly by `cin`. With `a=b=0` and `cin=1`, the result is `sum=1`, `cout=0`.
- R8: A carry entering at bit 0 ripples through every block when all intermediate bits propagate. Example: `a=16'hFFFF`, `b=0`, `cin=1` gives `sum=0`, `cout=1`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Low WIDTH bits of a + b + cin |
| cout | output | 1 | Carry out of the most significant bit |

## Verification
In a single evaluation, one block can make its own carry through generate while another block passes a carry through propagate alone. The two then meet at the select of the next block. The case to watch is a block whose propagate is 1 and generate is 0, because its sum choice and its outgoing carry both depend on the same late select. The bench provokes this with long runs of ones, with `cin=1`, and with operand pairs that complement each other. It also sweeps every input of small 7-bit instances in both layouts, where one block's carry and its neighbour's propagate coincide in every possible arrangement. Each result is judged against the arithmetic sum computed in the bench, masked to the instance width.

// File: rtl/csa_pkg.sv
package csa_pkg;

  typedef enum int {
    LAYOUT_UNIFORM     = 0,
    LAYOUT_PROGRESSIVE = 1
  } layout_e;

  // nominal width of block idx before truncation at the top
  function automatic int blk_span(input int idx, input int base, input layout_e lay);
    int b;
    b = (base < 1) ? 1 : base;
    if (lay == LAYOUT_PROGRESSIVE && idx >= 2) return b + idx - 1;
    return b;
  endfunction

  // lowest bit position of block idx
  function automatic int blk_lo(input int idx, input int base, input layout_e lay);
    int lo;
    lo = 0;
    for (int j = 0; j < idx; j++) lo += blk_span(j, base, lay);
    return lo;
  endfunction

  // number of blocks needed to cover width bits
  function automatic int blk_count(input int width, input int base, input layout_e lay);
    int n;
    int lo;
    n  = 0;
    lo = 0;
    while (lo < width) begin
      lo += blk_span(n, base, lay);
      n++;
    end
    return n;
  endfunction

endpackage

// File: rtl/csa_ripple.sv
module csa_ripple #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);

  logic [W:0] c;

  assign c[0] = ci;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign s[i]   = a[i] ^ b[i] ^ c[i];
    assign c[i+1] = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
  end

  assign co = c[W];

  // R1: each chain is an exact W-bit adder
  always_comb begin
    a_r1_ripple_exact : assert ({co, s} == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci}))
      else $error("ripple chain result mismatch");
  end

endmodule

// File: rtl/csa_select_block.sv
module csa_select_block #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);

  logic [W-1:0] s_zero;
  logic [W-1:0] s_one;
  logic         blk_gen;
  logic         blk_prop;

  csa_ripple #(.W(W)) u_zero (
    .a  (a),
    .b  (b),
    .ci (1'b0),
    .s  (s_zero),
    .co (blk_gen)
  );

  csa_ripple #(.W(W)) u_one (
    .a  (a),
    .b  (b),
    .ci (1'b1),
    .s  (s_one),
    .co (blk_prop)
  );

  assign s  = ci ? s_one : s_zero;
  assign co = blk_gen | (blk_prop & ci);

  always_comb begin
    // R4: a block that makes a carry on its own also passes one
    a_r4_gen_implies_prop : assert (!blk_gen || blk_prop)
      else $error("generate without propagate");
    // R3: the selected candidate plus block carry match the block arithmetic
    a_r3_block_exact : assert ({co, s} == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci}))
      else $error("block select mismatch");
  end

endmodule

// File: rtl/csa_adder.sv
module csa_adder #(
  parameter int               WIDTH  = 16,
  parameter int               BLK_W  = 4,
  parameter csa_pkg::layout_e LAYOUT = csa_pkg::LAYOUT_UNIFORM
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  localparam int NBLK = csa_pkg::blk_count(WIDTH, BLK_W, LAYOUT);
  localparam int W0   = (csa_pkg::blk_span(0, BLK_W, LAYOUT) > WIDTH)
                        ? WIDTH : csa_pkg::blk_span(0, BLK_W, LAYOUT);

  logic [NBLK:0] carry;

  assign carry[0] = cin;

  // R7: lowest block takes cin directly, single chain
  csa_ripple #(.W(W0)) u_low (
    .a  (a[W0-1:0]),
    .b  (b[W0-1:0]),
    .ci (carry[0]),
    .s  (sum[W0-1:0]),
    .co (carry[1])
  );

  for (genvar i = 1; i < NBLK; i++) begin : g_blk
    localparam int LO   = csa_pkg::blk_lo(i, BLK_W, LAYOUT);
    localparam int SPAN = csa_pkg::blk_span(i, BLK_W, LAYOUT);
    // R6: top block truncated to remaining bits
    localparam int BW   = (LO + SPAN > WIDTH) ? (WIDTH - LO) : SPAN;

    csa_select_block #(.W(BW)) u_sel (
      .a  (a[LO+BW-1:LO]),
      .b  (b[LO+BW-1:LO]),
      .ci (carry[i]),
      .s  (sum[LO+BW-1:LO]),
      .co (carry[i+1])
    );
  end

  assign cout = carry[NBLK];

  // R1 / R2: whole adder exact in either layout
  always_comb begin
    a_r1_top_exact : assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}))
      else $error("adder result mismatch");
  end

endmodule

// File: tb/sim_csa_adder.sv
module sim_csa_adder;

  logic clk;
  logic rst_n;

  logic [15:0] a16, b16;
  logic        c16;
  logic [15:0] s_uni, s_prg;
  logic        co_uni, co_prg;

  logic [6:0] a7, b7;
  logic       c7;
  logic [6:0] s7_uni, s7_prg;
  logic       co7_uni, co7_prg;

  int total;
  int bad;
  int cyc;

  csa_adder #(.WIDTH(16), .BLK_W(4), .LAYOUT(csa_pkg::LAYOUT_UNIFORM)) u0 (
    .a(a16), .b(b16), .cin(c16), .sum(s_uni), .cout(co_uni));
  csa_adder #(.WIDTH(16), .BLK_W(4), .LAYOUT(csa_pkg::LAYOUT_PROGRESSIVE)) u1 (
    .a(a16), .b(b16), .cin(c16), .sum(s_prg), .cout(co_prg));
  csa_adder #(.WIDTH(7), .BLK_W(3), .LAYOUT(csa_pkg::LAYOUT_UNIFORM)) u2 (
    .a(a7), .b(b7), .cin(c7), .sum(s7_uni), .cout(co7_uni));
  csa_adder #(.WIDTH(7), .BLK_W(2), .LAYOUT(csa_pkg::LAYOUT_PROGRESSIVE)) u3 (
    .a(a7), .b(b7), .cin(c7), .sum(s7_prg), .cout(co7_prg));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [16:0] ref16(input logic [15:0] x, input logic [15:0] y, input logic ci);
    return {1'b0, x} + {1'b0, y} + {16'd0, ci};
  endfunction

  function automatic logic [7:0] ref7(input logic [6:0] x, input logic [6:0] y, input logic ci);
    return {1'b0, x} + {1'b0, y} + {7'd0, ci};
  endfunction

  task automatic chk(input string tag, input logic [16:0] got, input logic [16:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic run16(input string tag_u, input string tag_p,
                       input logic [15:0] x, input logic [15:0] y, input logic ci);
    @(posedge clk);
    a16 = x; b16 = y; c16 = ci;
    @(negedge clk);
    chk(tag_u, {co_uni, s_uni}, ref16(x, y, ci));
    chk(tag_p, {co_prg, s_prg}, ref16(x, y, ci));
  endtask

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        total++;
        bad++;
        $display("FAIL watchdog expired got=%0d exp<150000", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] seed_dummy;
    total = 0;
    bad   = 0;
    rst_n = 1'b0;
    a16 = '0; b16 = '0; c16 = 1'b0;
    a7  = '0; b7  = '0; c7  = 1'b0;
    seed_dummy = $urandom(32'd1234);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // reset-time idle value
    @(negedge clk);
    chk("R1 idle zero", {co_uni, s_uni}, 17'd0);

    // directed corners
    run16("R7 cin only uni", "R7 cin only prg", 16'h0000, 16'h0000, 1'b1);
    run16("R3 block select uni", "R3 block select prg", 16'h000F, 16'h0000, 1'b1);
    run16("R3 carry zero select uni", "R3 carry zero select prg", 16'h00F0, 16'h0000, 1'b1);
    run16("R5 all ones uni", "R5 all ones prg", 16'hFFFF, 16'hFFFF, 1'b1);
    run16("R8 full chain uni", "R8 full chain prg", 16'hFFFF, 16'h0000, 1'b1);
    run16("R4 propagate only uni", "R4 propagate only prg", 16'hA5A5, 16'h5A5A, 1'b0);
    run16("R4 generate uni", "R4 generate prg", 16'h0808, 16'h0808, 1'b0);
    run16("R4 prop with carry uni", "R4 prop with carry prg", 16'h0FF0, 16'h000F, 1'b1);

    // random 16-bit vectors
    for (int k = 0; k < 3000; k++) begin
      logic [15:0] x, y;
      logic        ci;
      x  = 16'($urandom);
      y  = 16'($urandom);
      ci = 1'($urandom);
      if (k % 7 == 0) y = ~x;
      run16("R1 random uni", "R2 random prg", x, y, ci);
    end

    // exhaustive 7-bit: uniform 3-bit blocks (3,3,1) and progressive (2,2,3)
    for (int x = 0; x < 128; x++) begin
      for (int y = 0; y < 128; y++) begin
        for (int ci = 0; ci < 2; ci++) begin
          @(posedge clk);
          a7 = 7'(x); b7 = 7'(y); c7 = 1'(ci);
          @(negedge clk);
          chk("R6 truncated uni7", {9'd0, co7_uni, s7_uni}, {9'd0, ref7(7'(x), 7'(y), 1'(ci))});
          chk("R2 progressive 7", {9'd0, co7_prg, s7_prg}, {9'd0, ref7(7'(x), 7'(y), 1'(ci))});
        end
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule